// File: doc/BRIEF.md
# Cartridge ROM Select Lock Latch

This block is the glue between a serially loaded bank mapper and two 128 KB program ROMs on a game cartridge. It watches the mapper's five-bit character-bank register value and its write strobe. From them it produces the bank address lines for the lower ROM, passes the mapper's program-bank lines to the upper ROM, drives two active-low chip selects and holds a timer-clear control. Only the register decoded at $A000-$BFFF feeds this block. The register decoded at $C000-$DFFF is never connected.

After power-up or a board reset, a lock flip-flop keeps the outputs in a fixed state. The lower ROM is selected, its first 32 KB bank is forced and the timer is held clear. The lock opens when one register write has bit 4 at 0 and a later write has bit 4 at 1. From then on, bits 1 to 3 steer the ROM selection and bit 4 runs or clears the timer. Only the reset input closes the lock again.

This block carries no data stream, so none of its pins use a valid/ready handshake. Every pin is a plain level control. The outputs follow the register value combinationally, and the lock state changes on the clock edge that captures the unlocking write.

Top module: `rom_select_lock`

## Requirements
- R1: While locked (after reset, before unlock), `lo_bank` is 0, the upper ROM is never selected and `timer_clr` is 1, whatever `reg_val` holds.
- R2: Bit 0 of `reg_val` has no effect on any output, whether the block is locked or unlocked.
- R3: When unlocked with `reg_val[3]`=0, the lower ROM is selected and `lo_bank` equals `reg_val[2:1]`.
- R4: When unlocked with `reg_val[3]`=1, the upper ROM is selected.
- R5: The lock opens on the clock edge of a write (`reg_wr`=1) with `reg_val[4]`=1, but only if the previous write since reset had `reg_val[4]`=0. A first write after reset with bit 4 set does not unlock. A change of `reg_val` without `reg_wr` counts as no write.
- R6: When unlocked, `timer_clr` equals `reg_val[4]`: 0 lets the timer run and 1 clears it.
- R7: Once unlocked, the block stays unlocked until `rst_n` is asserted, whatever is written to bit 4.
- R8: `lo_cs_n` and `hi_cs_n` are active low. When `prg_rd`=1, exactly one of them is 0. When `prg_rd`=0, both are 1.
- R9: `hi_addr` always equals `prg_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock that samples the register write strobe |
| rst_n | input | 1 | Asynchronous active-low power-on or board reset |
| reg_wr | input | 1 | One-cycle strobe when the mapper loads its character-bank register |
| reg_val | input | 5 | Current character-bank register value from the mapper |
| prg_bank | input | 3 | The mapper's program-bank address lines |
| prg_rd | input | 1 | A program ROM read is in progress |
| lo_bank | output | 2 | 32 KB bank lines of the lower ROM |
| hi_addr | output | 3 | Bank address lines of the upper ROM |
| lo_cs_n | output | 1 | Active-low select of the lower ROM |
| hi_cs_n | output | 1 | Active-low select of the upper ROM |
| timer_clr | output | 1 | 1 holds the timer in reset and cleared |

## Verification
The assertions assume that `reg_val` only moves in ways the mapper can produce: it is stable around the clock edge at which `reg_wr` is high. They also assume `rst_n` is released away from a clock edge. The stimulus changes every input, including `rst_n`, half a cycle away from the rising edge, and it holds `reg_val` through the edge that carries each strobe. Random writes set bit 4 often enough to exercise many 0-then-1 unlocks and repeated toggles after unlock. Directed cases cover the first write after reset with bit 4 at 1, a changed `reg_val` with no strobe, and a reset applied after unlock.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int REG_W      = 5;
  localparam int LO_BANK_W  = 2;
  localparam int HI_ADDR_W  = 3;

  // field positions inside the character-bank register value
  localparam int BANK_LSB   = 1;
  localparam int ROM_SEL    = 3;
  localparam int CTRL_BIT   = 4;

  typedef enum logic {ROM_LO = 1'b0, ROM_HI = 1'b1} rom_e;

  typedef struct packed {
    logic [LO_BANK_W-1:0] bank;
    rom_e                 rom;
    logic                 tclr;
  } route_t;
endpackage

// File: rtl/rsl_lock.sv
module rsl_lock #(
  parameter int REG_W    = 5,
  parameter int CTRL_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] val,
  output logic             open_q
);
  // last written control bit; reset to 1 so a 0 must be written first
  logic prev_ctl_q;
  logic ctl_now;
  logic rise;

  assign ctl_now = val[CTRL_BIT];
  assign rise    = wr && ctl_now && !prev_ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ctl_q <= 1'b1;
      open_q     <= 1'b0;
    end else begin
      if (wr) prev_ctl_q <= ctl_now;
      if (rise) open_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rsl_route.sv
module rsl_route
  import rsl_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int LO_BANK_W = 2
) (
  input  logic             open_q,
  input  logic [REG_W-1:0] val,
  output route_t           route
);
  always_comb begin
    route.bank = '0;
    route.rom  = ROM_LO;
    route.tclr = 1'b1;
    if (open_q) begin
      route.bank = val[BANK_LSB +: LO_BANK_W];
      route.rom  = rom_e'(val[ROM_SEL]);
      route.tclr = val[CTRL_BIT];
    end
  end
endmodule

// File: rtl/rsl_chipsel.sv
module rsl_chipsel
  import rsl_pkg::*;
(
  input  logic rd,
  input  rom_e rom,
  output logic lo_cs_n,
  output logic hi_cs_n
);
  assign lo_cs_n = !(rd && (rom == ROM_LO));
  assign hi_cs_n = !(rd && (rom == ROM_HI));
endmodule

// File: rtl/rom_select_lock.sv
module rom_select_lock
  import rsl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_val,
  input  logic [HI_ADDR_W-1:0] prg_bank,
  input  logic                 prg_rd,
  output logic [LO_BANK_W-1:0] lo_bank,
  output logic [HI_ADDR_W-1:0] hi_addr,
  output logic                 lo_cs_n,
  output logic                 hi_cs_n,
  output logic                 timer_clr
);
  logic   open_q;
  route_t route;

  rsl_lock #(.REG_W(REG_W), .CTRL_BIT(CTRL_BIT)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .val(reg_val), .open_q(open_q)
  );

  rsl_route #(.REG_W(REG_W), .LO_BANK_W(LO_BANK_W)) u_route (
    .open_q(open_q), .val(reg_val), .route(route)
  );

  rsl_chipsel u_cs (
    .rd(prg_rd), .rom(route.rom), .lo_cs_n(lo_cs_n), .hi_cs_n(hi_cs_n)
  );

  assign lo_bank   = route.bank;
  assign hi_addr   = prg_bank;
  assign timer_clr = route.tclr;
endmodule

// File: rtl/rom_select_lock_chk.sv
module rom_select_lock_chk
  import rsl_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [REG_W-1:0]     reg_val,
  input logic [HI_ADDR_W-1:0] prg_bank,
  input logic                 prg_rd,
  input logic [LO_BANK_W-1:0] lo_bank,
  input logic [HI_ADDR_W-1:0] hi_addr,
  input logic                 lo_cs_n,
  input logic                 hi_cs_n,
  input logic                 timer_clr,
  input logic                 open_q
);
  p_forced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> (lo_bank == '0) && hi_cs_n && timer_clr);

  p_lo_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && prg_rd && !reg_val[ROM_SEL]) |-> !lo_cs_n && (lo_bank == reg_val[BANK_LSB +: LO_BANK_W]));

  p_hi_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && prg_rd && reg_val[ROM_SEL]) |-> !hi_cs_n);

  p_unlock_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(reg_wr && reg_val[CTRL_BIT]));

  p_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (timer_clr == reg_val[CTRL_BIT]));

  p_no_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q);

  p_one_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rd |-> ($countones({lo_cs_n, hi_cs_n}) == 1));

  p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prg_rd |-> (lo_cs_n && hi_cs_n));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_addr == prg_bank);
endmodule

bind rom_select_lock rom_select_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_val(reg_val),
  .prg_bank(prg_bank), .prg_rd(prg_rd), .lo_bank(lo_bank), .hi_addr(hi_addr),
  .lo_cs_n(lo_cs_n), .hi_cs_n(hi_cs_n), .timer_clr(timer_clr), .open_q(open_q)
);

// File: tb/rom_select_lock_tb_top.sv
module rom_select_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_val = '0;
  logic [2:0] prg_bank = '0;
  logic       prg_rd = 1'b0;
  logic [1:0] lo_bank;
  logic [2:0] hi_addr;
  logic       lo_cs_n, hi_cs_n, timer_clr;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  bit m_open = 1'b0;
  bit m_prev = 1'b1;

  always #10 clk = ~clk;

  rom_select_lock dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_val(reg_val),
    .prg_bank(prg_bank), .prg_rd(prg_rd), .lo_bank(lo_bank), .hi_addr(hi_addr),
    .lo_cs_n(lo_cs_n), .hi_cs_n(hi_cs_n), .timer_clr(timer_clr)
  );

  function automatic logic [1:0] exp_bank(bit op, logic [4:0] v);
    return op ? v[2:1] : 2'b00;
  endfunction
  function automatic bit exp_hi(bit op, logic [4:0] v);
    return op && v[3];
  endfunction
  function automatic bit exp_tclr(bit op, logic [4:0] v);
    return op ? v[4] : 1'b1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive inputs on the falling edge, check, then advance the model
  task automatic step(bit r, bit w, logic [4:0] v, logic [2:0] pb, bit rd, string req);
    bit hs;
    @(negedge clk);
    rst_n = r; reg_wr = w; reg_val = v; prg_bank = pb; prg_rd = rd;
    if (!r) begin m_open = 1'b0; m_prev = 1'b1; end
    #1;
    hs = exp_hi(m_open, v);
    chk(req, "lo_bank", lo_bank, exp_bank(m_open, v));
    chk(req, "timer_clr", timer_clr, exp_tclr(m_open, v));
    chk("R8", "lo_cs_n", lo_cs_n, !(rd && !hs));
    chk("R8", "hi_cs_n", hi_cs_n, !(rd && hs));
    chk("R9", "hi_addr", hi_addr, pb);
    if (r && w) begin
      if (v[4] && !m_prev) m_open = 1'b1;
      m_prev = v[4];
    end
  endtask

  task automatic expect_open(string req, bit e);
    // probe lock state through the ports: bit 3 set with a read
    step(1, 0, 5'b01000, 3'd5, 1, req);
    chk(req, "unlocked", !hi_cs_n, e);
  endtask

  initial begin : watchdog
    #3000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    step(0, 0, 5'b11111, 3'd7, 1, "R1");          // reset state, everything high
    step(1, 0, 5'b01110, 3'd2, 1, "R1");
    step(1, 1, 5'b11110, 3'd1, 1, "R5");          // first write has bit 4 = 1
    expect_open("R5", 0);
    step(1, 0, 5'b00000, 3'd0, 0, "R5");          // value 0 without strobe
    step(1, 0, 5'b10000, 3'd0, 0, "R5");          // value 1 without strobe
    expect_open("R5", 0);
    step(1, 1, 5'b00001, 3'd3, 1, "R2");          // write 0 to bit 4
    step(1, 1, 5'b10101, 3'd3, 1, "R5");          // write 1: unlocks at this edge
    expect_open("R5", 1);
    step(1, 0, 5'b00100, 3'd4, 1, "R3");          // bank 2, timer runs (R6)
    step(1, 0, 5'b00101, 3'd4, 1, "R2");          // bit 0 set: same outputs
    step(1, 0, 5'b01010, 3'd6, 1, "R4");
    step(1, 1, 5'b00000, 3'd6, 0, "R7");
    step(1, 1, 5'b10000, 3'd6, 0, "R7");
    step(1, 1, 5'b00000, 3'd6, 0, "R7");
    expect_open("R7", 1);
    step(0, 0, 5'b01110, 3'd1, 1, "R1");          // reset re-locks
    expect_open("R1", 0);

    for (int i = 0; i < 4000; i++) begin
      int unsigned rr;
      logic [4:0] v;
      rr = $urandom;
      v  = 5'($urandom);
      step((rr % 300) != 0, rr[8:6] < 3, v, 3'($urandom), rr[10],
           v[3] ? "R4" : (v[0] ? "R2" : "R3"));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule